// File: doc/BRIEF.md
# Mode-Switched UART Byte Queue Controller

This block keeps the two byte queues that sit between a host and the serial shift logic of a UART. It decides how deep both queues are (one entry, a small depth or a large depth) from a stored copy of the FIFO control byte, a compatibility-mode select and an enhanced-mode flag. It also clears a queue on command or when the mode changes, and it works out the transmit fill level at which a service request is raised.

The host writes the control byte, pushes transmit bytes and pops receive bytes. The transmitter shift logic pops from the transmit queue, and the receiver pushes into the receive queue. Both fill counts, the empty and full flags, a sticky overrun flag, the transmit request and a transmitter-idle indication are outputs.

The depth is held by a three-state machine with states Q_BYTE (one entry), Q_SMALL (SMALL_DEPTH entries) and Q_LARGE (LARGE_DEPTH entries). It has four transitions. OPEN goes from Q_BYTE to either FIFO state. CLOSE goes from a FIFO state back to Q_BYTE. GROW goes from Q_SMALL to Q_LARGE. SHRINK goes from Q_LARGE to Q_SMALL. The target state is evaluated every cycle from the stored control bits and the mode inputs, and the state register takes it on the next edge.

Top module: `ufifo_ctrl`

## Requirements
- R1: With control bit 0 clear (state Q_BYTE), each queue holds one byte, and its full flag is 1 while it holds that byte.
- R2: With control bit 0 set, the depth is SMALL_DEPTH, or LARGE_DEPTH when the enhanced flag is 1 or when compatibility code 4 (the 750-style mode) is selected with control bit 5 set.
- R3: With the enhanced flag at 0, a control write updates bit 5 only while the line-control bit 7 input is 1; otherwise the stored bit 5 keeps its old value.
- R4: A control write with bit 1 set empties the receive queue and one with bit 2 set empties the transmit queue, both only when the state before the write is not Q_BYTE. These bits are never stored, so later pushes are kept.
- R5: On OPEN or CLOSE the receive queue is emptied, while the transmit queue keeps its contents when they fit the new depth.
- R6: On any state change, a queue whose fill after that cycle's pushes and pops would exceed the new depth is emptied.
- R7: The transmit trigger level is 1 unless the enhanced flag is 1, compatibility code 3 (650-style) is selected and control bit 3 is set. Codes 0 to 2 are the 450, 550 and extended 550 styles.
- R8: When R7 does not force the level to 1, control bits 5:4 give the trigger level: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 112.
- R9: The transmit request is 1 exactly when the request enable is 1 and the transmit fill is below the trigger level.
- R10: A host write to a full transmit queue is dropped, even if the shifter pops in the same cycle.
- R11: A receiver push into a full receive queue is dropped and sets the overrun flag. A status read clears the flag, but a new overrun in the same cycle wins.
- R12: After reset both queues are empty, both levels are 0 and overrun is 0. The level outputs always equal the number of stored bytes.
- R13: The transmitter-idle output is 1 exactly when the transmit queue is empty and the shift-register-empty input is 1.
- R14: Bytes leave each queue in the order they were accepted. The head byte is visible on the pop data output while the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_wr | input | 1 | Strobe that writes the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte |
| lcr_dlab | input | 1 | Line-control bit 7, opens bit 5 for writing |
| compat_mode | input | 3 | Compatibility code: 0=450, 1=550, 2=ext 550, 3=650, 4=750 |
| enhanced | input | 1 | Enhanced-mode flag |
| host_tx_wr | input | 1 | Host push into the transmit queue |
| host_tx_data | input | DW | Byte pushed by the host |
| host_rx_rd | input | 1 | Host pop from the receive queue |
| host_rx_data | output | DW | Head of the receive queue |
| lsr_rd | input | 1 | Status read, clears overrun |
| tx_irq_en | input | 1 | Enable for the transmit request |
| ser_tx_pop | input | 1 | Shifter pop from the transmit queue |
| ser_tx_data | output | DW | Head of the transmit queue |
| tsr_empty | input | 1 | Transmit shift register is empty |
| ser_rx_push | input | 1 | Receiver push into the receive queue |
| ser_rx_data | input | DW | Byte pushed by the receiver |
| tx_level | output | LW | Transmit fill count |
| rx_level | output | LW | Receive fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at current depth |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at current depth |
| overrun | output | 1 | Sticky receive overrun flag |
| tx_irq | output | 1 | Transmit-level service request |
| tx_idle | output | 1 | Transmitter idle |

## Verification
The bench builds the block with its default parameters: SMALL_DEPTH of 16 and LARGE_DEPTH of 128 with 8-bit data. These are the values at which the fixed trigger levels of 16 to 112 fall inside the large depth, so every trigger code can be crossed in both directions by filling and draining the queue. With a 16-entry small depth, SHRINK with a fuller queue, full-queue drops and overrun are all reached within a few dozen cycles. Random control writes then mix OPEN, CLOSE, GROW and SHRINK with traffic that lands in the same cycle.

// File: rtl/ufifo_pkg.sv
package ufifo_pkg;

    typedef enum logic [2:0] {
        CM_450  = 3'd0,
        CM_550  = 3'd1,
        CM_X550 = 3'd2,
        CM_650  = 3'd3,
        CM_750  = 3'd4
    } compat_e;

    typedef enum logic [1:0] {
        Q_BYTE  = 2'd0,
        Q_SMALL = 2'd1,
        Q_LARGE = 2'd2
    } qstate_e;

endpackage

// File: rtl/ufifo_queue.sv
module ufifo_queue #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    parameter int LW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [LW-1:0] limit,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic [LW-1:0] count,
    output logic [LW-1:0] count_nxt,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count_q;
    logic          push_ok, pop_ok;

    assign empty   = (count_q == '0);
    assign full    = (count_q >= limit);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    assign count_nxt = count_q + LW'(push_ok) - LW'(pop_ok);
    assign count     = count_q;
    assign pop_data  = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok && !flush) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count_q <= count_nxt;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= limit);

    // R4
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0));

    // R10
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(count_q));

endmodule

// File: rtl/ufifo_cfg.sv
module ufifo_cfg
    import ufifo_pkg::*;
#(
    parameter int SMALL_DEPTH = 16,
    parameter int LARGE_DEPTH = 128,
    parameter int LW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_wdata,
    input  logic          lcr_dlab,
    input  logic [2:0]    compat_mode,
    input  logic          enhanced,
    input  logic [LW-1:0] tx_fill_nxt,
    input  logic [LW-1:0] rx_fill_nxt,
    output logic [LW-1:0] depth_limit,
    output logic [LW-1:0] trig_level,
    output logic          tx_flush,
    output logic          rx_flush
);
    qstate_e st_q, st_d;
    compat_e cmode;
    logic    fifo_en, trig_en, sel4, sel5;
    logic    bit5_open;
    logic    moved, crossing, cmd_ok;
    logic    [LW-1:0] lim_d;
    logic    unused_ctl;

    assign cmode      = compat_e'(compat_mode);
    assign bit5_open  = enhanced || lcr_dlab;
    assign unused_ctl = ^{fcr_wdata[7:6]};

    function automatic logic [LW-1:0] lim_of(input qstate_e s);
        logic [LW-1:0] v;
        unique case (s)
            Q_BYTE:  v = LW'(1);
            Q_SMALL: v = LW'(SMALL_DEPTH);
            Q_LARGE: v = LW'(LARGE_DEPTH);
            default: v = LW'(1);
        endcase
        return v;
    endfunction

    // stored control bits; flush bits 1 and 2 are never kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en <= 1'b0;
            trig_en <= 1'b0;
            sel4    <= 1'b0;
            sel5    <= 1'b0;
        end else if (fcr_wr) begin
            fifo_en <= fcr_wdata[0];
            trig_en <= fcr_wdata[3];
            sel4    <= fcr_wdata[4];
            if (bit5_open) sel5 <= fcr_wdata[5];
        end
    end

    // next-state: OPEN, CLOSE, GROW, SHRINK
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_BYTE: begin
                if (fifo_en) begin
                    st_d = (enhanced || (cmode == CM_750 && sel5)) ? Q_LARGE : Q_SMALL;
                end
            end
            Q_SMALL: begin
                if (!fifo_en) begin
                    st_d = Q_BYTE;
                end else if (enhanced || (cmode == CM_750 && sel5)) begin
                    st_d = Q_LARGE;
                end
            end
            Q_LARGE: begin
                if (!fifo_en) begin
                    st_d = Q_BYTE;
                end else if (!(enhanced || (cmode == CM_750 && sel5))) begin
                    st_d = Q_SMALL;
                end
            end
            default: st_d = Q_BYTE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= Q_BYTE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        depth_limit = lim_of(st_q);
        lim_d       = lim_of(st_d);
        moved       = (st_d != st_q);
        crossing    = (st_q == Q_BYTE) != (st_d == Q_BYTE);
        cmd_ok      = fcr_wr && (st_q != Q_BYTE);
        rx_flush    = (moved && (crossing || rx_fill_nxt > lim_d)) ||
                      (cmd_ok && fcr_wdata[1]);
        tx_flush    = (moved && tx_fill_nxt > lim_d) ||
                      (cmd_ok && fcr_wdata[2]);
        trig_level  = LW'(1);
        if (enhanced && cmode == CM_650 && trig_en) begin
            unique case ({sel5, sel4})
                2'b00: trig_level = LW'(16);
                2'b01: trig_level = LW'(32);
                2'b10: trig_level = LW'(64);
                2'b11: trig_level = LW'(112);
                default: trig_level = LW'(1);
            endcase
        end
    end

    // R3
    fcr5_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && !enhanced && !lcr_dlab) |=> $stable(sel5));

endmodule

// File: rtl/ufifo_ctrl.sv
module ufifo_ctrl
    import ufifo_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SMALL_DEPTH = 16,
    parameter int LARGE_DEPTH = 128,
    parameter int LW          = $clog2(LARGE_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fcr_wr,
    input  logic [7:0]    fcr_wdata,
    input  logic          lcr_dlab,
    input  logic [2:0]    compat_mode,
    input  logic          enhanced,
    input  logic          host_tx_wr,
    input  logic [DW-1:0] host_tx_data,
    input  logic          host_rx_rd,
    output logic [DW-1:0] host_rx_data,
    input  logic          lsr_rd,
    input  logic          tx_irq_en,
    input  logic          ser_tx_pop,
    output logic [DW-1:0] ser_tx_data,
    input  logic          tsr_empty,
    input  logic          ser_rx_push,
    input  logic [DW-1:0] ser_rx_data,
    output logic [LW-1:0] tx_level,
    output logic [LW-1:0] rx_level,
    output logic          tx_empty,
    output logic          tx_full,
    output logic          rx_empty,
    output logic          rx_full,
    output logic          overrun,
    output logic          tx_irq,
    output logic          tx_idle
);
    logic [LW-1:0] depth_limit, trig_level;
    logic [LW-1:0] tx_fill_nxt, rx_fill_nxt;
    logic          tx_flush, rx_flush;
    logic          ovr_q;

    ufifo_cfg #(
        .SMALL_DEPTH(SMALL_DEPTH),
        .LARGE_DEPTH(LARGE_DEPTH),
        .LW(LW)
    ) u_cfg (
        .clk(clk),
        .rst_n(rst_n),
        .fcr_wr(fcr_wr),
        .fcr_wdata(fcr_wdata),
        .lcr_dlab(lcr_dlab),
        .compat_mode(compat_mode),
        .enhanced(enhanced),
        .tx_fill_nxt(tx_fill_nxt),
        .rx_fill_nxt(rx_fill_nxt),
        .depth_limit(depth_limit),
        .trig_level(trig_level),
        .tx_flush(tx_flush),
        .rx_flush(rx_flush)
    );

    ufifo_queue #(.DEPTH(LARGE_DEPTH), .DW(DW), .LW(LW)) u_txq (
        .clk(clk),
        .rst_n(rst_n),
        .flush(tx_flush),
        .limit(depth_limit),
        .push(host_tx_wr),
        .push_data(host_tx_data),
        .pop(ser_tx_pop),
        .pop_data(ser_tx_data),
        .count(tx_level),
        .count_nxt(tx_fill_nxt),
        .empty(tx_empty),
        .full(tx_full)
    );

    ufifo_queue #(.DEPTH(LARGE_DEPTH), .DW(DW), .LW(LW)) u_rxq (
        .clk(clk),
        .rst_n(rst_n),
        .flush(rx_flush),
        .limit(depth_limit),
        .push(ser_rx_push),
        .push_data(ser_rx_data),
        .pop(host_rx_rd),
        .pop_data(host_rx_data),
        .count(rx_level),
        .count_nxt(rx_fill_nxt),
        .empty(rx_empty),
        .full(rx_full)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         ovr_q <= 1'b0;
        else if (ser_rx_push && rx_full)    ovr_q <= 1'b1;
        else if (lsr_rd)                    ovr_q <= 1'b0;
    end

    assign overrun = ovr_q;
    assign tx_irq  = tx_irq_en && (tx_level < trig_level);
    assign tx_idle = tx_empty && tsr_empty;

    // R11
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_push && rx_full) |=> overrun);

    // R9
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq_en && tx_level == '0) |-> tx_irq);

    // R13
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (tx_level == '0));

endmodule

// File: tb/tb_ufifo_ctrl.sv
module tb_ufifo_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int SMALL = 16;
    localparam int LARGE = 128;
    localparam int LW    = $clog2(LARGE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic lcr_dlab = 1'b0;
    logic [2:0] compat_mode = 3'd1;
    logic enhanced = 1'b0;
    logic host_tx_wr = 1'b0;
    logic [DW-1:0] host_tx_data = '0;
    logic host_rx_rd = 1'b0;
    logic [DW-1:0] host_rx_data;
    logic lsr_rd = 1'b0;
    logic tx_irq_en = 1'b0;
    logic ser_tx_pop = 1'b0;
    logic [DW-1:0] ser_tx_data;
    logic tsr_empty = 1'b1;
    logic ser_rx_push = 1'b0;
    logic [DW-1:0] ser_rx_data = '0;
    logic [LW-1:0] tx_level, rx_level;
    logic tx_empty, tx_full, rx_empty, rx_full, overrun, tx_irq, tx_idle;

    ufifo_ctrl #(.DW(DW), .SMALL_DEPTH(SMALL), .LARGE_DEPTH(LARGE)) dut (
        .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .lcr_dlab(lcr_dlab), .compat_mode(compat_mode), .enhanced(enhanced),
        .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
        .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
        .lsr_rd(lsr_rd), .tx_irq_en(tx_irq_en), .ser_tx_pop(ser_tx_pop),
        .ser_tx_data(ser_tx_data), .tsr_empty(tsr_empty),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
        .tx_level(tx_level), .rx_level(rx_level), .tx_empty(tx_empty),
        .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full),
        .overrun(overrun), .tx_irq(tx_irq), .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int m_st = 0;
    bit m_fen = 0, m_f3 = 0, m_f4 = 0, m_f5 = 0, m_ovr = 0;
    logic [7:0] mtx[$];
    logic [7:0] mrx[$];

    function automatic int lim_of(input int s);
        return (s == 0) ? 1 : ((s == 1) ? SMALL : LARGE);
    endfunction

    function automatic int tgt_of();
        if (!m_fen) return 0;
        if (enhanced || (compat_mode == 3'd4 && m_f5)) return 2;
        return 1;
    endfunction

    function automatic int trig_of();
        if (enhanced && compat_mode == 3'd3 && m_f3) begin
            case ({m_f5, m_f4})
                2'b00: return 16;
                2'b01: return 32;
                2'b10: return 64;
                default: return 112;
            endcase
        end
        return 1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int old_lim = lim_of(m_st);
        int nst = tgt_of();
        int nlim = lim_of(nst);
        bit txf = (mtx.size() >= old_lim);
        bit rxf = (mrx.size() >= old_lim);
        bit tx_fl = 0;
        bit rx_fl = 0;
        if (ser_tx_pop && mtx.size() > 0) void'(mtx.pop_front());
        if (host_tx_wr && !txf) mtx.push_back(host_tx_data);
        if (host_rx_rd && mrx.size() > 0) void'(mrx.pop_front());
        if (ser_rx_push && !rxf) mrx.push_back(ser_rx_data);
        if (nst != m_st) begin
            if ((m_st == 0) != (nst == 0)) rx_fl = 1;
            if (mrx.size() > nlim) rx_fl = 1;
            if (mtx.size() > nlim) tx_fl = 1;
        end
        if (fcr_wr && m_st != 0) begin
            if (fcr_wdata[1]) rx_fl = 1;
            if (fcr_wdata[2]) tx_fl = 1;
        end
        if (tx_fl) mtx.delete();
        if (rx_fl) mrx.delete();
        if (ser_rx_push && rxf) m_ovr = 1;
        else if (lsr_rd)        m_ovr = 0;
        if (fcr_wr) begin
            m_fen = fcr_wdata[0];
            m_f3  = fcr_wdata[3];
            m_f4  = fcr_wdata[4];
            if (enhanced || lcr_dlab) m_f5 = fcr_wdata[5];
        end
        m_st = nst;
    endtask

    task automatic compare_all();
        chk("R12 tx_level", int'(tx_level), mtx.size());
        chk("R12 rx_level", int'(rx_level), mrx.size());
        chk("R12 tx_empty", int'(tx_empty), int'(mtx.size() == 0));
        chk("R12 rx_empty", int'(rx_empty), int'(mrx.size() == 0));
        chk("R1 tx_full", int'(tx_full), int'(mtx.size() >= lim_of(m_st)));
        chk("R1 rx_full", int'(rx_full), int'(mrx.size() >= lim_of(m_st)));
        chk("R11 overrun", int'(overrun), int'(m_ovr));
        chk("R9 tx_irq", int'(tx_irq), int'(tx_irq_en && (mtx.size() < trig_of())));
        chk("R13 tx_idle", int'(tx_idle), int'(mtx.size() == 0 && tsr_empty));
        if (mtx.size() > 0) chk("R14 tx head", int'(ser_tx_data), int'(mtx[0]));
        if (mrx.size() > 0) chk("R14 rx head", int'(host_rx_data), int'(mrx[0]));
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        fcr_wr = 0; host_tx_wr = 0; host_rx_rd = 0;
        lsr_rd = 0; ser_tx_pop = 0; ser_rx_push = 0;
    endtask

    task automatic wr_fcr(input logic [7:0] d);
        fcr_wr = 1; fcr_wdata = d;
        step(); step(); step();
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin
            host_tx_wr = 1; host_tx_data = 8'($urandom);
            step();
        end
    endtask

    task automatic push_rx(input int n);
        for (int i = 0; i < n; i++) begin
            ser_rx_push = 1; ser_rx_data = 8'($urandom);
            step();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare_all();
        chk("R12 reset tx_level", int'(tx_level), 0);
        chk("R12 reset overrun", int'(overrun), 0);

        // byte mode
        push_tx(2);
        chk("R1 byte depth", int'(tx_level), 1);
        chk("R10 byte drop full", int'(tx_full), 1);

        // OPEN keeps transmit data
        wr_fcr(8'h01);
        chk("R5 tx kept on open", int'(tx_level), 1);
        push_tx(20);
        chk("R2 small depth", int'(tx_level), SMALL);
        chk("R10 full drop", int'(tx_full), 1);

        // bit 5 guard in 750 mode
        compat_mode = 3'd4;
        wr_fcr(8'h21);
        chk("R3 bit5 locked", int'(tx_full), 1);
        lcr_dlab = 1;
        wr_fcr(8'h21);
        lcr_dlab = 0;
        chk("R3 bit5 open", int'(tx_full), 0);
        chk("R2 large keeps fill", int'(tx_level), SMALL);
        push_tx(10);

        // SHRINK with too much data
        lcr_dlab = 1;
        wr_fcr(8'h01);
        lcr_dlab = 0;
        chk("R6 shrink flush", int'(tx_level), 0);

        // command flushes
        push_tx(5);
        wr_fcr(8'h05);
        chk("R4 tx cmd flush", int'(tx_level), 0);
        push_tx(3);
        chk("R4 self clearing", int'(tx_level), 3);
        push_rx(4);
        wr_fcr(8'h03);
        chk("R4 rx cmd flush", int'(rx_level), 0);

        // CLOSE with overfull tx, then flush ignored in byte mode
        wr_fcr(8'h00);
        chk("R6 close flush", int'(tx_level), 0);
        push_tx(1);
        wr_fcr(8'h04);
        chk("R4 byte mode ignores flush", int'(tx_level), 1);
        push_rx(1);
        wr_fcr(8'h01);
        chk("R5 rx flushed on open", int'(rx_level), 0);
        chk("R5 tx kept", int'(tx_level), 1);

        // trigger levels
        enhanced = 1; compat_mode = 3'd3; tx_irq_en = 1;
        wr_fcr(8'h09);
        chk("R8 below 16", int'(tx_irq), 1);
        push_tx(15);
        chk("R8 at 16", int'(tx_irq), 0);
        wr_fcr(8'h39);
        chk("R8 below 112", int'(tx_irq), 1);
        push_tx(96);
        chk("R8 at 112", int'(tx_irq), 0);
        ser_tx_pop = 1; step();
        chk("R9 falls below", int'(tx_irq), 1);
        compat_mode = 3'd1; step();
        chk("R7 other mode", int'(tx_irq), 0);
        compat_mode = 3'd3;
        wr_fcr(8'h31);
        chk("R7 bit3 clear", int'(tx_irq), 0);

        // overrun
        enhanced = 0;
        wr_fcr(8'h00);
        push_rx(2);
        chk("R11 overrun set", int'(overrun), 1);
        chk("R11 push dropped", int'(rx_level), 1);
        lsr_rd = 1; step();
        chk("R11 cleared", int'(overrun), 0);
        ser_rx_push = 1; lsr_rd = 1; step();
        chk("R11 set wins", int'(overrun), 1);

        // idle
        tsr_empty = 0; step();
        chk("R13 busy shifter", int'(tx_idle), 0);
        tsr_empty = 1; step();
        chk("R13 idle", int'(tx_idle), 1);

        // random phase
        for (int c = 0; c < 6000; c++) begin
            int bias = ((c / 500) % 2 == 0) ? 80 : 30;
            if ($urandom_range(199) == 0) enhanced = 1'($urandom);
            if ($urandom_range(199) == 0) compat_mode = 3'($urandom_range(4));
            lcr_dlab   = 1'($urandom);
            tx_irq_en  = ($urandom_range(9) != 0);
            tsr_empty  = 1'($urandom);
            if ($urandom_range(39) == 0) begin
                fcr_wr = 1;
                fcr_wdata = 8'($urandom);
                fcr_wdata[0] = ($urandom_range(6) != 0);
                if ($urandom_range(2) != 0) fcr_wdata[2:1] = 2'b00;
            end
            host_tx_wr   = ($urandom_range(99) < bias);
            host_tx_data = 8'($urandom);
            ser_tx_pop   = ($urandom_range(99) < 100 - bias);
            ser_rx_push  = ($urandom_range(99) < bias);
            ser_rx_data  = 8'($urandom);
            host_rx_rd   = ($urandom_range(99) < 100 - bias);
            lsr_rd       = ($urandom_range(9) == 0);
            step();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule